// File: doc/BRIEF.md
# Survivor Start-State Selector

When a trellis decoder purges states against a threshold, the set of states that survive changes from step to step. None of them is sure to be alive in any given step. Decoding of the survivor path therefore cannot always begin from a fixed state. This block takes one flag per trellis state, where a 1 marks a surviving state. It returns the index of the lowest-numbered surviving state and a bit that says whether any state survived at all.

The selection is built as a tree of four-input priority cells instead of one flat wide encoder. Each cell reports a two-bit winner code and an any-set bit. The any-set bits of one level become the request inputs of the level above. The index is assembled from the root's code down to the leaf's code. With the default of four levels the block covers 256 states and gives an 8-bit index. A parameter selects whether the result passes through an output register, which adds one cycle of latency.

Top module: `survivor_start_pick`

## Requirements
- R1: `startFound` is 1 exactly when at least one bit of `stateFlags` is 1.
- R2: When flags are set, `startIdx` equals the bit position of the lowest set flag. Bit i of `stateFlags` stands for state i.
- R3: When every flag is 0, both `startFound` and `startIdx` are 0.
- R4: The edge positions resolve correctly: a lone flag at bit 0 gives index 0, and a lone flag at bit 255 gives index 255.
- R5: Flags above the lowest set flag have no effect on `startIdx`.
- R6: With `REG_OUT` = 1 (the default), the outputs present the result for the flags sampled at the previous rising clock edge. A change of flags does not show at the outputs before that edge.
- R7: While `rstN` is low, the registered outputs hold 0 whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stateFlags | input | 4**LEVELS (256) | One survivor flag per state |
| startFound | output | 1 | At least one state survived |
| startIdx | output | 2*LEVELS (8) | Index of the lowest surviving state |

## Verification
With the default registered output, the result for a set of flags is due one rising edge after the flags are applied. The bench drives each new flag vector on a falling edge and queues its expected pair at the same moment. The monitor pops and compares one item 1 ns after the next rising edge, so every comparison lands at the first point where the new result can be valid. A separate check samples the outputs just after a new vector is driven and confirms they still show the previous result, which pins the latency to exactly one edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the output register this cycle
    logic primed;   // at least one edge has passed since reset
  } pickStrobe_t;

  // first node number of a tree level in heap order (root level 0)
  function automatic int levelBase(input int lv);
    return ((4 ** lv) - 1) / 3;
  endfunction

endpackage

// File: rtl/ssp_pe4_cell.sv
module ssp_pe4_cell (
  input  logic [3:0] req,
  output logic [1:0] code,
  output logic       any
);
  always_comb begin
    any = |req;
    if (req[0])      code = 2'd0;
    else if (req[1]) code = 2'd1;
    else if (req[2]) code = 2'd2;
    else if (req[3]) code = 2'd3;
    else             code = 2'd0;
  end
endmodule

// File: rtl/ssp_pick_tree.sv
module ssp_pick_tree #(
  parameter int LEVELS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [4**LEVELS-1:0]  flags,
  output logic                  treeFound,
  output logic [2*LEVELS-1:0]   treeIdx
);
  import ssp_pkg::*;

  localparam int NFLAGS = 4 ** LEVELS;
  localparam int IDX_W  = 2 * LEVELS;
  localparam int NODES  = ((4 ** LEVELS) - 1) / 3;

  logic             anyN [NODES];
  logic [IDX_W-1:0] idxN [NODES];

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    for (genvar k = 0; k < 4 ** lv; k++) begin : g_node
      localparam int N = levelBase(lv) + k;
      localparam int H = LEVELS - 1 - lv;
      logic [3:0] req;
      logic [1:0] code;
      logic       any;

      if (lv == LEVELS - 1) begin : g_leaf
        assign req     = flags[4*k +: 4];
        assign idxN[N] = IDX_W'(code);
      end else begin : g_inner
        logic [IDX_W-1:0] childIdx;
        assign req = {anyN[4*N+4], anyN[4*N+3], anyN[4*N+2], anyN[4*N+1]};
        always_comb begin
          case (code)
            2'd0:    childIdx = idxN[4*N+1];
            2'd1:    childIdx = idxN[4*N+2];
            2'd2:    childIdx = idxN[4*N+3];
            default: childIdx = idxN[4*N+4];
          endcase
        end
        assign idxN[N] = (IDX_W'(code) << (2 * H)) | childIdx;
      end

      ssp_pe4_cell u_cell (.req(req), .code(code), .any(any));
      assign anyN[N] = any;
    end
  end

  assign treeFound = anyN[0];
  assign treeIdx   = idxN[0];

  // every flag strictly below the chosen index
  logic [NFLAGS-1:0] lowMask;
  assign lowMask = (NFLAGS'(1) << treeIdx) - NFLAGS'(1);

  p_found_any_r1: assert property (@(posedge clk) disable iff (!rstN)
    treeFound == (|flags));
  p_idx_active_r2: assert property (@(posedge clk) disable iff (!rstN)
    treeFound |-> flags[treeIdx]);
  p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    !treeFound |-> (treeIdx == '0));
  p_lower_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    treeFound |-> ((flags & lowMask) == '0));

endmodule

// File: rtl/ssp_pick_ctrl.sv
module ssp_pick_ctrl #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  output ssp_pkg::pickStrobe_t strobe
);
  logic primedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  assign strobe.capture = REG_OUT;
  assign strobe.primed  = primedQ;
endmodule

// File: rtl/ssp_pick_datapath.sv
module ssp_pick_datapath #(
  parameter int LEVELS  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4**LEVELS-1:0] flags,
  input  ssp_pkg::pickStrobe_t strobe,
  output logic                 foundOut,
  output logic [2*LEVELS-1:0]  idxOut
);
  localparam int IDX_W = 2 * LEVELS;

  logic             treeFound;
  logic [IDX_W-1:0] treeIdx;

  ssp_pick_tree #(.LEVELS(LEVELS)) u_tree (
    .clk(clk), .rstN(rstN), .flags(flags),
    .treeFound(treeFound), .treeIdx(treeIdx)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        foundOut <= 1'b0;
        idxOut   <= '0;
      end else if (strobe.capture) begin
        foundOut <= treeFound;
        idxOut   <= treeIdx;
      end
    end

    p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.primed |-> (foundOut == $past(treeFound) && idxOut == $past(treeIdx)));
  end else begin : g_bypass
    assign foundOut = treeFound;
    assign idxOut   = treeIdx;
  end

endmodule

// File: rtl/survivor_start_pick.sv
module survivor_start_pick #(
  parameter int LEVELS  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4**LEVELS-1:0] stateFlags,
  output logic                 startFound,
  output logic [2*LEVELS-1:0]  startIdx
);
  ssp_pkg::pickStrobe_t strobe;

  ssp_pick_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe)
  );

  ssp_pick_datapath #(.LEVELS(LEVELS), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .flags(stateFlags), .strobe(strobe),
    .foundOut(startFound), .idxOut(startIdx)
  );
endmodule

// File: tb/survivor_start_pick_tb.sv
`timescale 1ns/1ps
module survivor_start_pick_tb;
  localparam int NF = 256;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NF-1:0] flags = '0;
  logic          found;
  logic [IW-1:0] idx;

  always #5 clk = ~clk;

  survivor_start_pick u_dut (
    .clk(clk), .rstN(rstN), .stateFlags(flags),
    .startFound(found), .startIdx(idx)
  );

  typedef struct {
    logic          f;
    logic [IW-1:0] i;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  exp_t lastExp;

  function automatic exp_t model(input logic [NF-1:0] v, input string tag);
    exp_t e;
    e.f = 1'b0; e.i = '0; e.tag = tag;
    for (int b = NF - 1; b >= 0; b--)
      if (v[b]) begin e.f = 1'b1; e.i = IW'(b); end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [NF-1:0] v, input string tag);
    @(negedge clk);
    flags = v;
    lastExp = model(v, tag);
    q.push_back(lastExp);
  endtask

  function automatic logic [NF-1:0] rnd(input bit sparse);
    logic [NF-1:0] v;
    for (int w = 0; w < NF / 32; w++) begin
      v[w*32 +: 32] = $urandom();
      if (sparse) v[w*32 +: 32] &= $urandom() & $urandom() & $urandom();
      if (sparse && ($urandom() % 3 != 0)) v[w*32 +: 32] = '0;
    end
    return v;
  endfunction

  // monitor: compare one result per rising edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rstN && q.size() > 0) begin
      e = q.pop_front();
      check(found === e.f, e.tag, "found", int'(found), int'(e.f));
      check(idx === e.i, e.tag, "index", int'(idx), int'(e.i));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog timeout");
    finishRun();
  end

  initial begin
    exp_t prev;
    logic [NF-1:0] v;
    // R7: outputs stay 0 in reset even with all flags set
    flags = '1;
    repeat (3) @(negedge clk);
    check(found === 1'b0, "R7", "found in reset", int'(found), 0);
    check(idx === '0, "R7", "index in reset", int'(idx), 0);
    rstN = 1'b1;

    drive('0, "R3");
    drive(NF'(1), "R4");
    drive(NF'(1) << 255, "R4");
    drive('1, "R1");
    drive((NF'(1) << 5) | (NF'(1) << 200), "R5");
    drive((NF'(1) << 63) | (NF'(1) << 64), "R5");
    drive(NF'(1) << 128, "R2");
    drive('0, "R3");
    for (int b = 0; b < NF; b++) drive(NF'(1) << b, "R2");
    for (int b = 0; b < NF; b++) drive({NF{1'b1}} << b, "R5");
    for (int n = 0; n < 150; n++) drive(rnd(1'b0), "R1");
    for (int n = 0; n < 150; n++) drive(rnd(1'b1), "R2");

    // R6: a new vector does not reach the outputs before the next edge
    drive(NF'(16), "R6");
    prev = lastExp;
    drive(NF'(1) << 200, "R6");
    #1;
    check(idx === prev.i, "R6", "index before edge", int'(idx), int'(prev.i));
    check(found === prev.f, "R6", "found before edge", int'(found), int'(prev.f));
    drive('0, "R3");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6", "results outstanding", q.size(), 0);
    finishRun();
  end
endmodule